// File: doc/BRIEF.md
# Multi-Mode Numerically Controlled Oscillator Bank

This block is a bank of four phase-accumulator oscillators running from one fixed master clock. Each channel emits a one-cycle clock-enable pulse whenever its accumulator wraps. The pulse streams feed the downstream clock dividers. The four channels have nominal rates of 19.44 MHz, 25.248 MHz, 32.768 MHz and 24.704 MHz. The 32.768 MHz channel is the reference channel.

An operating mode input selects where each channel's frequency correction comes from:
- **Normal:** the correction is the live word. It is taken from a signed input word, clamped to a programmable magnitude, and registered on a valid strobe.
- **Holdover:** the correction is a word captured earlier, while the bank was in normal mode.
- **Freerun:** no correction is applied, so each channel runs at its nominal rate relative to the master clock.

A derive input makes the three other channels take their correction from the clamped reference correction, scaled by the ratio of nominal rates.

Top module: `nco_bank`

## Requirements
- R1: While `rst_n` is low, `tick` is all zero. All accumulator, live and captured words reset to zero, so the first wraps after reset follow from a zero phase.
- R2: Mode code 2'b00 (freerun) adds exactly the nominal step floor(rate·2^32 / 100 MHz) to each 32-bit accumulator every cycle. Corrections present at that time have no effect. Code 2'b11 behaves as freerun.
- R3: Mode code 2'b01 (normal) adds nominal step + (live word << 12) each cycle, with sign extension. The live word is loaded when `corr_valid` is high at a clock edge and is first used one edge later. Channel c takes its word from `corr_in[16c+15:16c]`.
- R4: Before use, each incoming word is clamped to the range [−L, +L]. L is `corr_limit`, saturated at 32767.
- R5: With `derive_en` high, channels 0, 1 and 3 load floor(clampedE1 · Q / 65536) instead of their own word. clampedE1 is the clamped channel-2 word. Q is floor(rate·65536 / 32.768 MHz), which gives 38880, 50496 and 49408. Channel 2 loads its own clamped word unchanged.
- R6: `hold_capture` high in normal mode copies the live words into the holdover words at that edge. The copy takes the live value held before that edge. Mode code 2'b10 (holdover) adds nominal step + (holdover word << 12).
- R7: `hold_capture` in freerun or holdover mode leaves the holdover words unchanged.
- R8: A mode change alters the step from the same edge onward and never resets accumulator phase.
- R9: `tick[c]` is high for exactly the one cycle after a carry out of accumulator c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 freerun, 01 normal, 10 holdover, 11 freerun |
| derive_en | input | 1 | Derive channels 0, 1 and 3 from the channel-2 correction |
| corr_limit | input | 16 | Maximum correction magnitude |
| corr_in | input | 64 | Four signed 16-bit correction words, channel 0 in the low bits |
| corr_valid | input | 1 | Load the correction words |
| hold_capture | input | 1 | Copy the live words into the holdover words (normal mode only) |
| tick | output | 4 | Per-channel wrap pulses |

## Verification
All internal state is visible only through the timing of tick pulses. A wrong step, correction or captured word therefore appears as pulses that drift, at first by a single cycle after some wraps and then as a different pulse count per window. The bench runs a cycle-accurate reference model of the accumulators and compares every tick on every cycle. A corrupted live or holdover word is therefore caught at the first wrap whose timing it moves, usually within a few tens of cycles, given the 12-bit correction shift.

// File: rtl/nco_pkg.sv
package nco_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_NORM = 2'b01,
        MODE_HOLD = 2'b10,
        MODE_RSVD = 2'b11
    } nco_mode_e;

    // Phase step per master cycle for a given output rate
    function automatic logic [63:0] nominal_step(input longint unsigned rate_hz,
                                                 input longint unsigned mclk_hz,
                                                 input int unsigned acc_w);
        return (64'(rate_hz) << acc_w) / 64'(mclk_hz);
    endfunction

    // Unsigned Q16 ratio between a channel rate and the reference rate
    function automatic logic [17:0] ratio_q16(input longint unsigned rate_hz,
                                              input longint unsigned ref_hz);
        return 18'((64'(rate_hz) << 16) / 64'(ref_hz));
    endfunction

endpackage

// File: rtl/nco_limiter.sv
module nco_limiter #(
    parameter int unsigned CORR_W = 16
) (
    input  logic [CORR_W-1:0] raw,
    input  logic [CORR_W-1:0] limit,
    output logic [CORR_W-1:0] clamped
);
    localparam logic [CORR_W-1:0] MAXPOS = {1'b0, {(CORR_W-1){1'b1}}};

    logic [CORR_W-1:0]        lim_cap;
    logic signed [CORR_W:0]   raw_x;
    logic signed [CORR_W:0]   lim_x;
    logic signed [CORR_W:0]   neg_x;

    always_comb begin
        lim_cap = (limit > MAXPOS) ? MAXPOS : limit;
        raw_x   = {raw[CORR_W-1], raw};
        lim_x   = {1'b0, lim_cap};
        neg_x   = -lim_x;
        if (raw_x > lim_x) begin
            clamped = lim_cap;
        end else if (raw_x < neg_x) begin
            clamped = neg_x[CORR_W-1:0];
        end else begin
            clamped = raw;
        end
    end
endmodule

// File: rtl/nco_ratio_scale.sv
module nco_ratio_scale #(
    parameter int unsigned CORR_W = 16,
    parameter logic [17:0] RATIO  = 18'd65536
) (
    input  logic [CORR_W-1:0] corr,
    output logic [CORR_W-1:0] scaled
);
    localparam int unsigned PW = CORR_W + 18;

    logic signed [PW-1:0] a_x;
    logic signed [PW-1:0] r_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        a_x     = PW'($signed(corr));
        r_x     = PW'($signed({1'b0, RATIO}));
        prod    = a_x * r_x;
        shifted = prod >>> 16;
        scaled  = shifted[CORR_W-1:0];
    end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int unsigned ACC_W      = 32,
    parameter int unsigned CORR_W     = 16,
    parameter int unsigned CORR_SHIFT = 12,
    parameter logic [63:0] NOM_STEP   = 64'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORR_W-1:0] corr,
    output logic              tick
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W-1:0] corr_x;
    logic [ACC_W-1:0] step;
    logic [ACC_W:0]   sum;

    always_comb begin
        corr_x    = ACC_W'($signed(corr));
        step      = NOM_STEP[ACC_W-1:0] + (corr_x << CORR_SHIFT);
        sum       = {1'b0, st_q.acc} + {1'b0, step};
        st_d.acc  = sum[ACC_W-1:0];
        st_d.tick = sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    // Step stays below half the phase range, so pulses are never adjacent
    assert_tick_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);

    // Phase is never reset by anything but reset itself
    assert_phase_continuous_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (st_q.acc == ACC_W'($past(st_q.acc) + $past(step))));
endmodule

// File: rtl/nco_bank.sv
module nco_bank #(
    parameter int unsigned ACC_W      = 32,
    parameter int unsigned CORR_W     = 16,
    parameter int unsigned CORR_SHIFT = 12,
    parameter int unsigned NCH        = 4,
    parameter int unsigned E1_IDX     = 2,
    parameter int unsigned MCLK_HZ    = 100000000,
    parameter int unsigned RATE_HZ [NCH] = '{19440000, 25248000, 32768000, 24704000}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode,
    input  logic                  derive_en,
    input  logic [CORR_W-1:0]     corr_limit,
    input  logic [NCH*CORR_W-1:0] corr_in,
    input  logic                  corr_valid,
    input  logic                  hold_capture,
    output logic [NCH-1:0]        tick
);
    import nco_pkg::*;

    typedef logic [NCH-1:0][CORR_W-1:0] bank_t;

    typedef struct packed {
        bank_t live;
        bank_t hold;
    } bank_st_t;

    bank_st_t  st_d, st_q;
    bank_t     clamped;
    bank_t     scaled;
    bank_t     chosen;
    bank_t     applied;
    nco_mode_e mode_e;

    assign mode_e = nco_mode_e'(mode);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [63:0] NOM   = nominal_step(RATE_HZ[g], MCLK_HZ, ACC_W);
        localparam logic [17:0] RATIO = ratio_q16(RATE_HZ[g], RATE_HZ[E1_IDX]);

        nco_limiter #(.CORR_W(CORR_W)) u_lim (
            .raw     (corr_in[g*CORR_W +: CORR_W]),
            .limit   (corr_limit),
            .clamped (clamped[g])
        );

        nco_ratio_scale #(.CORR_W(CORR_W), .RATIO(RATIO)) u_scale (
            .corr   (clamped[E1_IDX]),
            .scaled (scaled[g])
        );

        nco_phase_acc #(
            .ACC_W      (ACC_W),
            .CORR_W     (CORR_W),
            .CORR_SHIFT (CORR_SHIFT),
            .NOM_STEP   (NOM)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .corr  (applied[g]),
            .tick  (tick[g])
        );

        // Loaded words never exceed the limit in effect at load time
        assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (corr_valid && !derive_en && ($past(rst_n) || 1'b1)) |=>
                (($signed({st_q.live[g][CORR_W-1], st_q.live[g]}) <=
                  $signed({1'b0, $past(corr_limit)})) &&
                 ($signed({st_q.live[g][CORR_W-1], st_q.live[g]}) >=
                  -$signed({1'b0, $past(corr_limit)}))));
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            chosen[i] = (derive_en && (i != E1_IDX)) ? scaled[i] : clamped[i];
            case (mode_e)
                MODE_NORM: applied[i] = st_q.live[i];
                MODE_HOLD: applied[i] = st_q.hold[i];
                default:   applied[i] = '0;
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (corr_valid) begin
            st_d.live = chosen;
        end
        if (hold_capture && (mode_e == MODE_NORM)) begin
            st_d.hold = st_q.live;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_live_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_valid |=> $stable(st_q.live));

    assert_hold_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_capture && (mode == 2'b01)) |=> (st_q.hold == $past(st_q.live)));

    assert_hold_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_capture && (mode == 2'b01)) |=> $stable(st_q.hold));
endmodule

// File: tb/nco_bank_tb.sv
module nco_bank_tb;
    localparam int NCH = 4;
    localparam longint RATES [NCH] = '{19440000, 25248000, 32768000, 24704000};
    localparam longint MCLK = 100000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        derive_en = 1'b0;
    logic [15:0] corr_limit = 16'd32767;
    logic [63:0] corr_in = '0;
    logic        corr_valid = 1'b0;
    logic        hold_capture = 1'b0;
    logic [3:0]  tick;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nco_bank u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .derive_en(derive_en),
        .corr_limit(corr_limit), .corr_in(corr_in), .corr_valid(corr_valid),
        .hold_capture(hold_capture), .tick(tick)
    );

    // ---------------- reference model from the requirements ----------------
    longint m_acc [NCH];
    longint m_live [NCH];
    longint m_hold [NCH];
    bit     m_tick [NCH];
    longint dcnt [NCH];
    longint mcnt [NCH];
    int     mism = 0;
    int     adjacent = 0;
    bit     prev_tick [NCH];

    function automatic longint nom(input int c);
        return (RATES[c] * 64'd4294967296) / MCLK;
    endfunction

    function automatic longint clampw(input logic [15:0] raw, input logic [15:0] lim);
        longint l, v;
        l = (lim > 16'd32767) ? 32767 : longint'(lim);
        v = longint'($signed(raw));
        if (v > l) return l;
        if (v < -l) return -l;
        return v;
    endfunction

    function automatic longint scalew(input longint v, input int c);
        longint q;
        q = (RATES[c] * 65536) / RATES[2];
        return (v * q) >>> 16;
    endfunction

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_acc[c] = 0; m_live[c] = 0; m_hold[c] = 0; m_tick[c] = 0;
            dcnt[c] = 0; mcnt[c] = 0; prev_tick[c] = 0;
        end
    end

    always @(posedge clk) begin
        longint eff, s, e1;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_acc[c] = 0; m_live[c] = 0; m_hold[c] = 0; m_tick[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (mode == 2'b01) eff = m_live[c];
                else if (mode == 2'b10) eff = m_hold[c];
                else eff = 0;
                s = m_acc[c] + ((nom(c) + eff * 4096) & 64'hFFFF_FFFF);
                m_tick[c] = s[32];
                m_acc[c] = s & 64'hFFFF_FFFF;
            end
            if (hold_capture && mode == 2'b01)
                for (int c = 0; c < NCH; c++) m_hold[c] = m_live[c];
            if (corr_valid) begin
                e1 = clampw(corr_in[47:32], corr_limit);
                for (int c = 0; c < NCH; c++) begin
                    if (derive_en && c != 2) m_live[c] = scalew(e1, c);
                    else m_live[c] = clampw(corr_in[c*16 +: 16], corr_limit);
                end
            end
        end
    end

    always begin
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++) begin
            dcnt[c] += tick[c];
            mcnt[c] += m_tick[c];
            if (tick[c] !== m_tick[c]) mism++;
            if (tick[c] && prev_tick[c]) adjacent++;
            prev_tick[c] = tick[c];
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_window(input string req, input int n);
        longint db [NCH];
        longint mb [NCH];
        int     m0;
        for (int c = 0; c < NCH; c++) begin db[c] = dcnt[c]; mb[c] = mcnt[c]; end
        m0 = mism;
        repeat (n) @(negedge clk);
        for (int c = 0; c < NCH; c++)
            check($sformatf("%s ch%0d count", req, c), dcnt[c] - db[c], mcnt[c] - mb[c]);
        check($sformatf("%s per-cycle tick match", req), mism - m0, 0);
    endtask

    task automatic load(input logic [15:0] w0, input logic [15:0] w1,
                        input logic [15:0] w2, input logic [15:0] w3);
        @(negedge clk);
        corr_in = {w3, w2, w1, w0};
        corr_valid = 1'b1;
        @(negedge clk);
        corr_valid = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_r1();
        repeat (4) @(negedge clk);
        check("R1 tick low in reset", tick, 0);
        rst_n = 1'b1;
        run_window("R1", 40);
    endtask

    task automatic t_freerun_r2();
        longint b;
        mode = 2'b00;
        load(16'd9000, -16'sd9000, 16'd12000, 16'd7000);
        b = dcnt[2];
        run_window("R2", 4000);
        checks++;
        if (dcnt[2] - b < 1309 || dcnt[2] - b > 1312) begin
            errors++;
            $display("FAIL R2 ch2 freerun count actual=%0d expected=1310..1311", dcnt[2] - b);
        end
        mode = 2'b11;
        run_window("R2 code11", 1000);
    endtask

    task automatic t_normal_r3();
        corr_limit = 16'd32767;
        derive_en = 1'b0;
        load(16'd3000, -16'sd2000, 16'd15000, -16'sd800);
        mode = 2'b01;
        run_window("R3", 3000);
    endtask

    task automatic t_clamp_r4();
        corr_limit = 16'd1000;
        load(16'd20000, -16'sd20000, 16'd500, 16'h8000);
        run_window("R4", 2000);
        corr_limit = 16'hFFFF;
        load(16'h8000, 16'd32767, -16'sd5, 16'd0);
        run_window("R4 saturated limit", 1500);
    endtask

    task automatic t_derive_r5();
        corr_limit = 16'd30000;
        derive_en = 1'b1;
        load(16'd111, 16'd222, 16'd20000, 16'd333);
        run_window("R5", 2500);
        load(16'd0, 16'd0, -16'sd17001, 16'd0);
        run_window("R5 negative", 2500);
        derive_en = 1'b0;
    endtask

    task automatic t_holdover_r6_r7();
        load(16'd6000, -16'sd6000, 16'd9000, 16'd1234);
        @(negedge clk);
        hold_capture = 1'b1;
        @(negedge clk);
        hold_capture = 1'b0;
        load(-16'sd9000, 16'd9000, -16'sd9000, 16'd9000);
        mode = 2'b10;
        run_window("R6", 3000);
        mode = 2'b00;
        hold_capture = 1'b1;
        @(negedge clk);
        hold_capture = 1'b0;
        mode = 2'b10;
        hold_capture = 1'b1;
        @(negedge clk);
        hold_capture = 1'b0;
        run_window("R7", 3000);
    endtask

    task automatic t_switch_r8();
        load(16'd14000, -16'sd14000, 16'd14000, -16'sd3000);
        for (int k = 0; k < 60; k++) begin
            mode = 2'((k * 7) % 3);
            repeat (37) @(negedge clk);
        end
        run_window("R8", 500);
    endtask

    task automatic t_pulse_r9();
        check("R9 no adjacent tick pulses", adjacent, 0);
    endtask

    // ---------------- watchdog and sequencing ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_freerun_r2();
        t_normal_r3();
        t_clamp_r4();
        t_derive_r5();
        t_holdover_r6_r7();
        t_switch_r8();
        t_pulse_r9();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule